// File: doc/BRIEF.md
# Banked Address Generation Unit

This unit turns the 16-bit register values of a small CPU into wide physical addresses. Six 8-bit bank registers live inside the unit: a code bank, a staged code bank, a general index bank, a page register, and one bank for each of the two pointer registers. An addressing-mode select picks how the 24-bit logical address is built. The low 21 bits of that address go to the external bus.

Code fetches are banked only in the upper half of the program counter space. When PC bit 15 is clear, the fetch address is PC itself. When PC bit 15 is set, the code bank supplies the bits above PC[14:0]. Software never changes the code bank directly while running banked code. It loads the staged bank, and the next jump copies the staged value into the code bank. The data modes prefix a 16-bit offset with a bank register. The direct-page mode concatenates a bank, a page byte and the low byte of the immediate.

Bank registers are written through one write port: an enable, a 3-bit select and an 8-bit value. The write takes effect at the next rising clock edge. The address outputs are combinational from the register state and the current inputs.

Top module: `bank_agu`

## Requirements
- R1: While reset is low, all six bank registers are held at 0, and bank writes made during reset are dropped. After reset, every banked mode therefore yields its 16-bit offset with zero upper bits.
- R2: In mode 0 (code fetch), when pc[15] is 0, laddr equals pc zero-extended.
- R3: In mode 0, when pc[15] is 1, laddr equals code_bank*2^15 + pc[14:0]. This is a 23-bit value with laddr[23] = 0.
- R4: In mode 1 (HL-indexed), laddr = index_bank*2^16 + hl.
- R5: In mode 2 (X-indexed), laddr = x_bank*2^16 + x.
- R6: In mode 3 (Y-indexed), laddr = y_bank*2^16 + y.
- R7: In mode 4 (direct page), laddr = index_bank*2^16 + page*2^8 + imm[7:0]. imm[15:8] has no effect.
- R8: In mode 5 (absolute immediate), laddr = index_bank*2^16 + imm.
- R9: baddr always equals laddr modulo 2^21.
- R10: Setting bank_we with bank_sel selects the target register: 0 code bank, 1 staged bank, 2 index bank, 3 page, 4 x bank, 5 y bank. The register changes at the next rising edge and not before it. Select values 6 and 7 change no register.
- R11: When jump is high at a rising edge, the code bank takes the value the staged bank held before that edge. This holds even if the staged bank is written in the same cycle. The new staged value reaches the code bank only on a later jump.
- R12: When a jump and a code-bank write happen in the same cycle, the jump wins and the write is lost. With no jump and no code-bank write, the code bank holds its value.
- R13: Mode codes 6 and 7 give laddr = 0 and baddr = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 3 | Addressing-mode select (0 code, 1 HL, 2 X, 3 Y, 4 page, 5 absolute) |
| pc | input | 16 | Program counter |
| hl | input | 16 | HL register |
| x | input | 16 | X pointer register |
| y | input | 16 | Y pointer register |
| imm | input | 16 | Immediate operand; the page mode uses only the low byte |
| jump | input | 1 | A jump executes this cycle |
| bank_we | input | 1 | Bank register write enable |
| bank_sel | input | 3 | Bank register select |
| bank_wdata | input | 8 | Bank register write value |
| laddr | output | 24 | Logical address |
| baddr | output | 21 | External bus address |

## Verification
The bench checks the PC values on both sides of the bit-15 boundary (0x7FFF, 0x8000, 0xFFFF). A unit that banked every fetch, or dropped bit 14, would show a wrong upper byte on exactly those probes.

The bench writes the staged bank in the same cycle as a jump. A unit that forwarded the new staged value would load it into the code bank one jump early. A jump is also paired with a direct code-bank write, to catch a priority inversion.

Bank patterns with bits 5 to 7 set expose a bus address that fails to wrap at 2^21. The two spare select codes and the two spare mode codes are probed to show that they leave every register, and the address, untouched.

// File: rtl/bank_agu_pkg.sv
package bank_agu_pkg;

  typedef enum logic [2:0] {
    AM_CODE = 3'd0,
    AM_HL   = 3'd1,
    AM_XIDX = 3'd2,
    AM_YIDX = 3'd3,
    AM_PAGE = 3'd4,
    AM_ABS  = 3'd5
  } am_e;

  localparam int BK_V      = 0;
  localparam int BK_U      = 1;
  localparam int BK_I      = 2;
  localparam int BK_N      = 3;
  localparam int BK_XI     = 4;
  localparam int BK_YI     = 5;
  localparam int NUM_BANKS = 6;
  localparam int SEL_W     = $clog2(NUM_BANKS);

endpackage

// File: rtl/bank_agu_regs.sv
module bank_agu_regs
  import bank_agu_pkg::*;
#(
  parameter int BANK_W = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              jump,
  input  logic                              we,
  input  logic [SEL_W-1:0]                  sel,
  input  logic [BANK_W-1:0]                 wdata,
  output logic [NUM_BANKS-1:0][BANK_W-1:0]  banks,
  output logic                              v_write_lost
);

  logic [NUM_BANKS-1:0] wr_hit;

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    assign wr_hit[g] = we && (sel == SEL_W'(g));

    if (g == BK_V) begin : g_code
      always_ff @(posedge clk) begin
        if (!rst_n)
          banks[g] <= '0;
        else if (jump)
          banks[g] <= banks[BK_U];
        else if (wr_hit[g])
          banks[g] <= wdata;
      end
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (!rst_n)
          banks[g] <= '0;
        else if (wr_hit[g])
          banks[g] <= wdata;
      end
    end
  end

  assign v_write_lost = jump && wr_hit[BK_V];

endmodule

// File: rtl/bank_agu_form.sv
module bank_agu_form
  import bank_agu_pkg::*;
#(
  parameter int REG_W  = 16,
  parameter int BANK_W = 8,
  localparam int LA_W  = REG_W + BANK_W
) (
  input  logic [2:0]        mode,
  input  logic [REG_W-1:0]  pc,
  input  logic [REG_W-1:0]  hl,
  input  logic [REG_W-1:0]  x,
  input  logic [REG_W-1:0]  y,
  input  logic [REG_W-1:0]  imm,
  input  logic [BANK_W-1:0] v_bank,
  input  logic [BANK_W-1:0] i_bank,
  input  logic [BANK_W-1:0] n_bank,
  input  logic [BANK_W-1:0] xi_bank,
  input  logic [BANK_W-1:0] yi_bank,
  output logic [LA_W-1:0]   laddr
);

  function automatic logic [LA_W-1:0] f_code(input logic [REG_W-1:0] p,
                                             input logic [BANK_W-1:0] b);
    if (p[REG_W-1])
      return LA_W'({b, p[REG_W-2:0]});
    else
      return LA_W'(p);
  endfunction

  function automatic logic [LA_W-1:0] f_far(input logic [BANK_W-1:0] b,
                                            input logic [REG_W-1:0] off);
    return {b, off};
  endfunction

  function automatic logic [LA_W-1:0] f_page(input logic [BANK_W-1:0] b,
                                             input logic [BANK_W-1:0] pg,
                                             input logic [REG_W-1:0] lo);
    return LA_W'({b, pg, lo[BANK_W-1:0]});
  endfunction

  always_comb begin
    case (am_e'(mode))
      AM_CODE: laddr = f_code(pc, v_bank);
      AM_HL:   laddr = f_far(i_bank, hl);
      AM_XIDX: laddr = f_far(xi_bank, x);
      AM_YIDX: laddr = f_far(yi_bank, y);
      AM_PAGE: laddr = f_page(i_bank, n_bank, imm);
      AM_ABS:  laddr = f_far(i_bank, imm);
      default: laddr = '0;
    endcase
  end

endmodule

// File: rtl/bank_agu.sv
module bank_agu
  import bank_agu_pkg::*;
#(
  parameter int REG_W  = 16,
  parameter int BANK_W = 8,
  parameter int BUS_W  = 21,
  localparam int LA_W  = REG_W + BANK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        mode,
  input  logic [REG_W-1:0]  pc,
  input  logic [REG_W-1:0]  hl,
  input  logic [REG_W-1:0]  x,
  input  logic [REG_W-1:0]  y,
  input  logic [REG_W-1:0]  imm,
  input  logic              jump,
  input  logic              bank_we,
  input  logic [SEL_W-1:0]  bank_sel,
  input  logic [BANK_W-1:0] bank_wdata,
  output logic [LA_W-1:0]   laddr,
  output logic [BUS_W-1:0]  baddr
);

  logic [NUM_BANKS-1:0][BANK_W-1:0] banks;
  logic [BANK_W-1:0] v_bank, u_bank, i_bank, n_bank, xi_bank, yi_bank;
  logic              v_write_lost;

  bank_agu_regs #(.BANK_W(BANK_W)) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .jump         (jump),
    .we           (bank_we),
    .sel          (bank_sel),
    .wdata        (bank_wdata),
    .banks        (banks),
    .v_write_lost (v_write_lost)
  );

  assign v_bank  = banks[BK_V];
  assign u_bank  = banks[BK_U];
  assign i_bank  = banks[BK_I];
  assign n_bank  = banks[BK_N];
  assign xi_bank = banks[BK_XI];
  assign yi_bank = banks[BK_YI];

  bank_agu_form #(.REG_W(REG_W), .BANK_W(BANK_W)) u_form (
    .mode    (mode),
    .pc      (pc),
    .hl      (hl),
    .x       (x),
    .y       (y),
    .imm     (imm),
    .v_bank  (v_bank),
    .i_bank  (i_bank),
    .n_bank  (n_bank),
    .xi_bank (xi_bank),
    .yi_bank (yi_bank),
    .laddr   (laddr)
  );

  assign baddr = laddr[BUS_W-1:0];

endmodule

// File: rtl/bank_agu_chk.sv
module bank_agu_chk #(
  parameter int REG_W  = 16,
  parameter int BANK_W = 8,
  parameter int BUS_W  = 21,
  localparam int LA_W  = REG_W + BANK_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        mode,
  input logic [REG_W-1:0]  pc,
  input logic [REG_W-1:0]  hl,
  input logic [REG_W-1:0]  imm,
  input logic              jump,
  input logic              bank_we,
  input logic [2:0]        bank_sel,
  input logic [BANK_W-1:0] bank_wdata,
  input logic [LA_W-1:0]   laddr,
  input logic [BUS_W-1:0]  baddr,
  input logic [BANK_W-1:0] v_bank,
  input logic [BANK_W-1:0] u_bank,
  input logic [BANK_W-1:0] i_bank,
  input logic [BANK_W-1:0] n_bank,
  input logic              v_write_lost
);

  AST_CODE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd0 && !pc[REG_W-1]) |-> laddr == LA_W'(pc)); // R2

  AST_CODE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd0 && pc[REG_W-1]) |-> laddr == LA_W'({v_bank, pc[REG_W-2:0]})); // R3

  AST_HL_FORM: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd1) |-> laddr == {i_bank, hl}); // R4

  AST_PAGE_FORM: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd4) |-> laddr == LA_W'({i_bank, n_bank, imm[BANK_W-1:0]})); // R7

  AST_BUS_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd1) |-> baddr == BUS_W'({i_bank, hl})); // R9

  AST_STAGED_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_we && bank_sel == 3'd1) |=> u_bank == $past(bank_wdata)); // R10

  AST_JUMP_TAKES_OLD: assert property (@(posedge clk) disable iff (!rst_n)
    jump |=> v_bank == $past(u_bank)); // R11

  AST_LOST_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    v_write_lost |=> v_bank == $past(u_bank)); // R12

  AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!jump && !(bank_we && bank_sel == 3'd0)) |=> $stable(v_bank)); // R12

  AST_SPARE_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode > 3'd5) |-> (laddr == '0 && baddr == '0)); // R13

endmodule

bind bank_agu bank_agu_chk #(.REG_W(REG_W), .BANK_W(BANK_W), .BUS_W(BUS_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .mode         (mode),
  .pc           (pc),
  .hl           (hl),
  .imm          (imm),
  .jump         (jump),
  .bank_we      (bank_we),
  .bank_sel     (bank_sel),
  .bank_wdata   (bank_wdata),
  .laddr        (laddr),
  .baddr        (baddr),
  .v_bank       (v_bank),
  .u_bank       (u_bank),
  .i_bank       (i_bank),
  .n_bank       (n_bank),
  .v_write_lost (v_write_lost)
);

// File: tb/tb_bank_agu.sv
module tb_bank_agu;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  mode = '0;
  logic [15:0] pc = '0, hl = '0, x = '0, y = '0, imm = '0;
  logic        jump = 1'b0;
  logic        bank_we = 1'b0;
  logic [2:0]  bank_sel = '0;
  logic [7:0]  bank_wdata = '0;
  logic [23:0] laddr;
  logic [20:0] baddr;

  int total = 0;
  int bad = 0;
  bit done = 0;

  int mv = 0, mu = 0, mi = 0, mn = 0, mxi = 0, myi = 0;

  always #5 clk = ~clk;

  bank_agu dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .pc(pc), .hl(hl), .x(x), .y(y),
    .imm(imm), .jump(jump), .bank_we(bank_we), .bank_sel(bank_sel),
    .bank_wdata(bank_wdata), .laddr(laddr), .baddr(baddr)
  );

  task automatic chk(input string tag, input int unsigned act, input int unsigned exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic int unsigned exp_la(input int md, input int unsigned p,
      input int unsigned h, input int unsigned xv, input int unsigned yv,
      input int unsigned im);
    case (md)
      0: return (p >= 32768) ? mv * 32768 + (p - 32768) : p;
      1: return mi * 65536 + h;
      2: return mxi * 65536 + xv;
      3: return myi * 65536 + yv;
      4: return mi * 65536 + mn * 256 + (im % 256);
      5: return mi * 65536 + im;
      default: return 0;
    endcase
  endfunction

  function automatic string mode_tag(input int md, input int unsigned p);
    case (md)
      0: return (p >= 32768) ? "R3" : "R2";
      1: return "R4";
      2: return "R5";
      3: return "R6";
      4: return "R7";
      5: return "R8";
      default: return "R13";
    endcase
  endfunction

  task automatic probe(input string tag, input int md, input int unsigned p,
      input int unsigned h, input int unsigned xv, input int unsigned yv,
      input int unsigned im);
    int unsigned e;
    mode = 3'(md); pc = 16'(p); hl = 16'(h); x = 16'(xv); y = 16'(yv); imm = 16'(im);
    #1;
    e = exp_la(md, p, h, xv, yv, im);
    chk((tag != "") ? tag : mode_tag(md, p), laddr, e);
    chk("R9", baddr, e % 2097152);
  endtask

  task automatic model_wr(input int s, input int d);
    case (s)
      0: mv = d;
      1: mu = d;
      2: mi = d;
      3: mn = d;
      4: mxi = d;
      5: myi = d;
      default: ;
    endcase
  endtask

  task automatic wrb(input int s, input int d);
    @(negedge clk);
    bank_we = 1'b1; bank_sel = 3'(s); bank_wdata = 8'(d);
    @(negedge clk);
    bank_we = 1'b0;
    model_wr(s, d);
  endtask

  task automatic all_modes(input string tag);
    for (int md = 0; md < 8; md++) begin
      probe(tag, md, 16'h8123, 16'h4567, 16'h89AB, 16'hCDEF, 16'h3C5A);
      probe(tag, md, 16'h0F0F, 16'hF0F0, 16'h00FF, 16'hFF00, 16'hA55A);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int unsigned pats[8];
    int unsigned bvals[8];
    int uold;
    pats  = '{16'h0000, 16'h7FFF, 16'h8000, 16'hFFFF, 16'h1234, 16'hABCD, 16'h4000, 16'hC001};
    bvals = '{8'h00, 8'hFF, 8'hA5, 8'h1F, 8'h20, 8'hE0, 8'h5A, 8'h01};

    // R1: writes during reset are dropped
    bank_we = 1'b1; bank_sel = 3'd2; bank_wdata = 8'hFF;
    repeat (3) @(negedge clk);
    bank_we = 1'b0;
    rst_n = 1'b1;
    all_modes("R1");
    probe("R1", 0, 16'hFFFF, 0, 0, 0, 0);

    // R1: jump after reset keeps the code bank at 0
    @(negedge clk); jump = 1'b1; @(negedge clk); jump = 1'b0;
    probe("R1", 0, 16'hFFFF, 0, 0, 0, 0);

    // sweep of bank values, modes and register patterns
    for (int b = 0; b < 8; b++) begin
      wrb(0, bvals[b]);
      wrb(1, bvals[b] ^ 8'h3C);
      wrb(2, (bvals[b] + 1) % 256);
      wrb(3, 255 - bvals[b]);
      wrb(4, bvals[b] ^ 8'h55);
      wrb(5, (bvals[b] + 7) % 256);
      for (int p = 0; p < 8; p++)
        for (int md = 0; md < 8; md++)
          probe("", md, pats[p], pats[(p + 1) % 8], pats[(p + 2) % 8],
                pats[(p + 5) % 8], pats[(p + 3) % 8]);
    end

    // R7: imm high byte has no effect in page mode
    wrb(2, 8'h9C); wrb(3, 8'h42);
    probe("R7", 4, 0, 0, 0, 0, 16'h0077);
    probe("R7", 4, 0, 0, 0, 0, 16'hFF77);

    // R10: change is seen only after the edge
    mode = 3'd1; hl = 16'h0000;
    @(negedge clk);
    bank_we = 1'b1; bank_sel = 3'd2; bank_wdata = 8'h5A;
    #1 chk("R10", laddr, mi * 65536);
    @(posedge clk); #1;
    chk("R10", laddr, 32'h5A * 65536);
    @(negedge clk); bank_we = 1'b0; mi = 8'h5A;

    // R10: spare select codes touch nothing
    wrb(6, 8'hEE);
    wrb(7, 8'h77);
    all_modes("R10");
    @(negedge clk); jump = 1'b1; @(negedge clk); jump = 1'b0; mv = mu;
    probe("R10", 0, 16'h8001, 0, 0, 0, 0);

    // R11: staged write in the jump cycle does not forward
    wrb(1, 8'h33);
    @(negedge clk);
    jump = 1'b1; bank_we = 1'b1; bank_sel = 3'd1; bank_wdata = 8'hC7;
    @(negedge clk);
    jump = 1'b0; bank_we = 1'b0;
    mv = 8'h33; mu = 8'hC7;
    probe("R11", 0, 16'hFFFF, 0, 0, 0, 0);
    @(negedge clk); jump = 1'b1; @(negedge clk); jump = 1'b0; mv = mu;
    probe("R11", 0, 16'h8000, 0, 0, 0, 0);

    // R12: jump beats a direct code-bank write
    uold = mu;
    @(negedge clk);
    jump = 1'b1; bank_we = 1'b1; bank_sel = 3'd0; bank_wdata = 8'h11;
    @(negedge clk);
    jump = 1'b0; bank_we = 1'b0; mv = uold;
    probe("R12", 0, 16'hC000, 0, 0, 0, 0);
    // R12: holds with no jump and no code write
    wrb(1, 8'h6B);
    repeat (3) @(negedge clk);
    probe("R12", 0, 16'hC000, 0, 0, 0, 0);
    // direct code-bank write without jump
    wrb(0, 8'hF3);
    probe("R10", 0, 16'hFFFF, 0, 0, 0, 0);

    // R13 spare modes with nonzero banks
    probe("R13", 6, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF);
    probe("R13", 7, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule